// File: doc/BRIEF.md
# Registered-Load Binary Counter

The block is a binary up counter that takes its preset value from a holding register. One bidirectional bus serves two purposes. When the outputs are off, the bus carries data into the holding register. When the outputs are on, the bus carries the count out through tri-state drivers. The holding register and the counter each run on their own rising-edge clock. A gate input qualifies the holding register clock. An enable pair qualifies the counter clock. One input of that pair is active-high and the other is active-low.

The counter has two asynchronous controls, clear and load, and both override counting. Load copies the holding register into the counter. Clear takes priority over load. An active-low ripple output goes low while the count is all ones and counting is enabled. Counters are chained by wiring this ripple output into the active-low count enable of the next stage.

Top module: `regload_counter`

## Requirements
- R1: On a rising `regClk` edge with `regClkEn` high, the holding register takes the value on `ioBus`. With `regClkEn` low, the holding register keeps its value.
- R2: While `clrN` is low, the count is zero at once, with no counter clock edge needed. This holds even while `loadN` is also low.
- R3: While `loadN` is low and `clrN` is high, the count equals the holding register at once, with no counter clock edge needed.
- R4: On a rising `cntClk` edge the count goes up by one only when `cntEnHi` is 1 and `cntEnLoN` is 0. Under the other three combinations the count stays unchanged.
- R5: An enabled counter clock edge moves a count of all ones (hex FF) to zero.
- R6: The count is on `ioBus` only when `outEnHi` is 1 and `outEnLoN` is 0. Otherwise the block releases the bus, and a value driven from outside appears on it unchanged.
- R7: `rippleN` is 0 exactly when the count is hex FF and counting is enabled (`cntEnHi`=1, `cntEnLoN`=0). In every other case it is 1.
- R8: Two stages chain when the `rippleN` of the first stage drives the `cntEnLoN` of the second stage, which has `cntEnHi`=1. The pair then counts as one 16-bit counter: the first stage holds the low byte and the second stage holds the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| regClk | input | 1 | Holding register clock, rising edge |
| regClkEn | input | 1 | Holding register clock gate, active-high |
| cntClk | input | 1 | Counter clock, rising edge |
| clrN | input | 1 | Asynchronous counter clear, active-low |
| loadN | input | 1 | Asynchronous load from holding register, active-low |
| cntEnHi | input | 1 | Count enable, active-high half of the pair |
| cntEnLoN | input | 1 | Count enable, active-low half of the pair |
| outEnHi | input | 1 | Output enable, active-high half of the pair |
| outEnLoN | input | 1 | Output enable, active-low half of the pair |
| ioBus | inout | 8 | Shared bus: holding register input or count output |
| rippleN | output | 1 | Terminal-count pulse, active-low |

## Verification
The test loads every start value from 00 to FF through the bus and the holding register, then applies one enabled counter edge to each. This sweep separates a correct increment from a wrong one and catches a bad wrap at FF. For each start value, the three disabled enable combinations show that only the asserted pair advances the count. The ripple output is checked at FF and at every other value, both with counting enabled and with it disabled. Separate runs check the order of clear and load, the holding register clock gate, release of the bus under each output-enable combination, and a two-stage chain run over 773 edges.

// File: rtl/regcnt_pkg.sv
package regcnt_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic count;
    logic drive;
  } cntStrobes_t;
endpackage

// File: rtl/regcnt_ctrl.sv
module regcnt_ctrl
  import regcnt_pkg::*;
(
  input  logic        clrN,
  input  logic        loadN,
  input  logic        cntEnHi,
  input  logic        cntEnLoN,
  input  logic        outEnHi,
  input  logic        outEnLoN,
  input  logic        atMax,
  output cntStrobes_t strobes,
  output logic        rippleN
);
  logic countOk;

  assign countOk = cntEnHi & ~cntEnLoN;

  // clear dominates load; counting is only a clocked qualifier
  always_comb begin
    strobes.clear = ~clrN;
    strobes.load  = ~loadN & clrN;
    strobes.count = countOk;
    strobes.drive = outEnHi & ~outEnLoN;
  end

  assign rippleN = ~(atMax & countOk);
endmodule

// File: rtl/regcnt_dp.sv
module regcnt_dp
  import regcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             regClk,
  input  logic             regClkEn,
  input  logic             cntClk,
  input  cntStrobes_t      strobes,
  inout  wire [WIDTH-1:0]  ioBus,
  output logic             atMax,
  output logic [WIDTH-1:0] countVal
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  logic [WIDTH-1:0] holdReg;
  logic [WIDTH-1:0] count;
  logic             clearAct;
  logic             loadAct;
  logic             seenEdge;

  assign clearAct = strobes.clear;
  assign loadAct  = strobes.load;

  always_ff @(posedge regClk) begin
    if (regClkEn) holdReg <= ioBus;
  end

  always_ff @(posedge cntClk or posedge clearAct or posedge loadAct) begin
    if (clearAct)           count <= '0;
    else if (loadAct)       count <= holdReg;
    else if (strobes.count) count <= count + 1'b1;
  end

  assign ioBus    = strobes.drive ? count : 'z;
  assign atMax    = (count == TOP_VAL);
  assign countVal = count;

  always_ff @(posedge cntClk or posedge clearAct or posedge loadAct) begin
    if (clearAct || loadAct) seenEdge <= 1'b0;
    else                     seenEdge <= 1'b1;
  end

  // R2: clear forces zero whenever it is seen at a clock edge
  p_clear_zero_r2: assert property (@(posedge cntClk) strobes.clear |-> count == '0);

  // R3: a held load keeps the counter equal to the holding register
  p_load_copies_r3: assert property (@(posedge cntClk) disable iff (strobes.clear)
    strobes.load |-> count == holdReg);

  // R4, R5: one enabled edge advances by exactly one, modulo 2^WIDTH
  p_count_step_r4: assert property (@(posedge cntClk) disable iff (clearAct || loadAct)
    (seenEdge && $past(strobes.count)) |-> count == WIDTH'($past(count) + 1'b1));

  // R4: without enable the value is kept across an edge
  p_count_hold_r4: assert property (@(posedge cntClk) disable iff (clearAct || loadAct)
    (seenEdge && !$past(strobes.count)) |-> $stable(count));
endmodule

// File: rtl/regload_counter.sv
module regload_counter
  import regcnt_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             regClk,
  input  logic             regClkEn,
  input  logic             cntClk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic             cntEnHi,
  input  logic             cntEnLoN,
  input  logic             outEnHi,
  input  logic             outEnLoN,
  inout  wire [WIDTH-1:0]  ioBus,
  output logic             rippleN
);
  cntStrobes_t      strobes;
  logic             atMax;
  logic [WIDTH-1:0] countVal;

  regcnt_ctrl u_ctrl (
    .clrN     (clrN),
    .loadN    (loadN),
    .cntEnHi  (cntEnHi),
    .cntEnLoN (cntEnLoN),
    .outEnHi  (outEnHi),
    .outEnLoN (outEnLoN),
    .atMax    (atMax),
    .strobes  (strobes),
    .rippleN  (rippleN)
  );

  regcnt_dp #(.WIDTH(WIDTH)) u_dp (
    .regClk   (regClk),
    .regClkEn (regClkEn),
    .cntClk   (cntClk),
    .strobes  (strobes),
    .ioBus    (ioBus),
    .atMax    (atMax),
    .countVal (countVal)
  );

  // R7: the terminal pulse only appears on an all-ones count
  p_ripple_at_top_r7: assert property (@(posedge cntClk) disable iff (!clrN)
    !rippleN |-> countVal == {WIDTH{1'b1}});
endmodule

// File: tb/regload_counter_tb.sv
module regload_counter_tb;
  localparam int W = 8;

  logic regClk = 0, regClkEn = 0, cntClk = 0;
  logic clrN = 0, loadN = 1;
  logic cntEnHi = 0, cntEnLoN = 1, outEnHi = 0, outEnLoN = 1;
  logic tbDrive = 0;
  logic [W-1:0] tbVal = '0;
  wire  [W-1:0] busW;
  wire  [W-1:0] bus2;
  logic rippleN, rippleHi;

  int errs = 0, checks = 0;
  bit done = 0;

  assign busW = tbDrive ? tbVal : 'z;

  always #4 cntClk = ~cntClk;

  regload_counter #(.WIDTH(W)) u_dut (
    .regClk(regClk), .regClkEn(regClkEn), .cntClk(cntClk), .clrN(clrN), .loadN(loadN),
    .cntEnHi(cntEnHi), .cntEnLoN(cntEnLoN), .outEnHi(outEnHi), .outEnLoN(outEnLoN),
    .ioBus(busW), .rippleN(rippleN));

  // second stage for the chaining check
  regload_counter #(.WIDTH(W)) u_hi (
    .regClk(1'b0), .regClkEn(1'b0), .cntClk(cntClk), .clrN(clrN), .loadN(1'b1),
    .cntEnHi(1'b1), .cntEnLoN(rippleN), .outEnHi(1'b1), .outEnLoN(1'b0),
    .ioBus(bus2), .rippleN(rippleHi));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic readCount(output logic [W-1:0] v);
    tbDrive = 0; outEnHi = 1; outEnLoN = 0;
    #1 v = busW;
    outEnHi = 0; outEnLoN = 1;
  endtask

  task automatic writeHold(logic [W-1:0] v, logic gate);
    outEnHi = 0; outEnLoN = 1;
    tbDrive = 1; tbVal = v; regClkEn = gate;
    #1 regClk = 1;
    #1 regClk = 0; regClkEn = 0; tbDrive = 0;
  endtask

  task automatic pulseLoad();
    #0.5 loadN = 0;
    #0.5 loadN = 1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [W-1:0] got;
    @(negedge cntClk); @(negedge cntClk);
    // R2: reset state under clear
    readCount(got); chk("R2 reset count", got, 0);
    chk("R7 reset ripple", rippleN, 1);
    clrN = 1;

    // R1, R3: gated capture, async load
    @(negedge cntClk);
    writeHold(8'hA5, 1);
    writeHold(8'h3C, 0);
    pulseLoad();
    readCount(got); chk("R1/R3 gated capture then load", got, 8'hA5);

    // R2: clear wins over simultaneous load
    @(negedge cntClk);
    clrN = 0; loadN = 0;
    readCount(got); chk("R2 clear over load", got, 0);
    loadN = 1; #0.5 clrN = 1;
    readCount(got); chk("R2 cleared after release", got, 0);

    // R6: bus release under every output-enable pair
    for (int c = 0; c < 4; c++) begin
      @(negedge cntClk);
      outEnHi = c[0]; outEnLoN = c[1];
      tbDrive = (c != 1); tbVal = 8'h5A;
      #1 chk("R6 bus content", busW, (c == 1) ? 0 : 8'h5A);
      tbDrive = 0; outEnHi = 0; outEnLoN = 1;
    end

    // R3, R4, R5, R7: sweep every start value
    for (int v = 0; v < 256; v++) begin
      @(negedge cntClk);
      cntEnHi = 0; cntEnLoN = 1;
      writeHold(W'(v), 1);
      pulseLoad();
      readCount(got); chk("R3 load value", got, v);
      for (int c = 0; c < 3; c++) begin
        cntEnHi = (c == 1); cntEnLoN = (c != 2);
        #0.5 chk("R7 ripple disabled", rippleN, 1);
        @(negedge cntClk);
        readCount(got); chk("R4 no advance when disabled", got, v);
      end
      cntEnHi = 1; cntEnLoN = 0;
      #0.5 chk("R7 ripple enabled", rippleN, (v == 255) ? 0 : 1);
      @(negedge cntClk);
      cntEnHi = 0; cntEnLoN = 1;
      readCount(got);
      chk((v == 255) ? "R5 wrap to zero" : "R4 advance by one", got, (v + 1) % 256);
    end

    // R8: two-stage chain
    @(negedge cntClk);
    clrN = 0;
    #1 clrN = 1;
    cntEnHi = 1; cntEnLoN = 0;
    repeat (773) @(negedge cntClk);
    cntEnHi = 0; cntEnLoN = 1;
    readCount(got); chk("R8 low stage", got, 773 % 256);
    #0.5 chk("R8 high stage", bus2, 773 / 256);

    finishRun();
  end
endmodule